// File: doc/BRIEF.md
# Reset Boot-Path Sequencer

After every reset this block decides where execution begins. It first looks at the reset cause. A watchdog-triggered reset goes straight to a check of the user vector table. Any other reset consults an external boot-select pin, which can send the part into in-system programming or on to the same table check.

The table check reads a fixed number of words from the low region of flash through a request/acknowledge read port. It adds the words with 32-bit wrap-around arithmetic. A sum of exactly zero marks the user program as valid. The sequencer then switches the exception-vector remap over to user flash and, one cycle later, pulses a start strobe for the processor. A nonzero sum, or a low boot pin on a non-watchdog reset, raises a programming-mode request instead.

Either outcome sets a completion flag. The machine then stays frozen until the next reset.

Top module: `boot_path_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, memReq, remapUser, goUser, enterIsp and seqDone are all 0.
- R2: When wdtFlag is 1 at the check after reset, the table is validated whatever the level of bootPin.
- R3: When wdtFlag is 0 and the synchronized bootPin is 0, enterIsp is raised and no table read is made.
- R4: When wdtFlag is 0 and the synchronized bootPin is 1, the table is validated.
- R5: Validation reads VEC_WORDS words, one for each cycle in which memReq and memAck are both high. The word with index i is read at byte address VEC_BASE + 4*i. memReq and memAddr hold steady until memAck arrives, whatever the delay.
- R6: If the 32-bit wrap-around sum of the words is zero, remapUser rises and stays at 1. goUser then pulses high for exactly one cycle, starting one cycle after remapUser rises.
- R7: If the sum is nonzero, enterIsp rises and holds at 1. remapUser stays 0 and goUser never pulses.
- R8: seqDone rises with either outcome and stays at 1. After that, changes on wdtFlag, bootPin and memAck leave every output unchanged.
- R9: A new reset returns the block to its initial state, and the decision runs again from the start.
- R10: bootPin is sampled once, in a dedicated state. Changing it during the table read does not alter the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wdtFlag | input | 1 | 1 when the last reset came from the watchdog |
| bootPin | input | 1 | External boot-select level (asynchronous) |
| memAck | input | 1 | Read acknowledge; memData is valid while high |
| memData | input | DATA_W | Read data from the vector region |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | ADDR_W | Byte address of the requested word |
| remapUser | output | 1 | 1 selects user flash for the exception vectors |
| goUser | output | 1 | One-cycle start strobe for the user program |
| enterIsp | output | 1 | Level request to enter in-system programming |
| seqDone | output | 1 | Decision made; inputs now ignored |

## Verification
With a zero-latency responder, the acceptance of the last table word falls in the same cycle as the withdrawal of the read request. A missed or extra read would show up in the read count that the responder keeps, and in the address it checks on every read. A second collision is provoked after completion: a spurious acknowledge and flips of the reset cause and boot pin are driven together, and all outputs must hold their frozen values. The bench also drops the boot pin while the table is still being read. This judges that the pin sample taken earlier is the only one that counts.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK_WDT,
    S_SAMPLE_PIN,
    S_SUM,
    S_DECIDE,
    S_USER,
    S_ISP
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic clear;   // restart word index and accumulator
    logic fetch;   // issue table reads
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic pinLevel;    // synchronized boot-select level
    logic lastAccept;  // final table word accepted this cycle
    logic sumZero;     // accumulator equals zero
  } dpStatus_t;

endpackage

// File: rtl/boot_seq_datapath.sv
module boot_seq_datapath
  import boot_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VEC_WORDS   = 8,
  parameter int unsigned VEC_BASE    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              bootPin,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output dpStatus_t         status
);

  localparam int unsigned IDX_W          = (VEC_WORDS > 1) ? $clog2(VEC_WORDS) : 1;
  localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(VEC_WORDS - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [IDX_W-1:0]       wordIdx;
  logic [DATA_W-1:0]      acc;
  logic                   accept;

  // boot-pin synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= bootPin;
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], bootPin};
      end
    end
  endgenerate

  assign memReq = strobes.fetch;
  assign accept = strobes.fetch & memAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      acc     <= '0;
    end else if (strobes.clear) begin
      wordIdx <= '0;
      acc     <= '0;
    end else if (accept) begin
      wordIdx <= wordIdx + 1'b1;
      acc     <= acc + memData;
    end
  end

  assign memAddr = ADDR_W'(VEC_BASE) + ADDR_W'(wordIdx) * ADDR_W'(BYTES_PER_WORD);

  assign status.pinLevel   = syncReg[SYNC_STAGES-1];
  assign status.lastAccept = accept && (wordIdx == LAST_IDX);
  assign status.sumZero    = (acc == '0);

  // R5: address of a pending read does not move before its acknowledge
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));

  // R5: a pending read is not withdrawn before its acknowledge
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R9: a restart leaves the accumulator empty
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> status.sumZero);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wdtFlag,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         remapUser,
  output logic         goUser,
  output logic         enterIsp,
  output logic         seqDone
);

  seqState_t state, nextState;
  logic      launched;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:       nextState = S_CHECK_WDT;
      S_CHECK_WDT:  nextState = wdtFlag ? S_SUM : S_SAMPLE_PIN;
      S_SAMPLE_PIN: nextState = status.pinLevel ? S_SUM : S_ISP;
      S_SUM:        nextState = status.lastAccept ? S_DECIDE : S_SUM;
      S_DECIDE:     nextState = status.sumZero ? S_USER : S_ISP;
      S_USER:       nextState = S_USER;
      S_ISP:        nextState = S_ISP;
      default:      nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remapUser <= 1'b0;
      goUser    <= 1'b0;
      launched  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_DECIDE && status.sumZero) remapUser <= 1'b1;
      goUser <= (state == S_USER) && !launched;
      if (state == S_USER) launched <= 1'b1;
    end
  end

  assign strobes.clear = (state == S_IDLE);
  assign strobes.fetch = (state == S_SUM);
  assign enterIsp      = (state == S_ISP);
  assign seqDone       = (state == S_USER) || (state == S_ISP);

  // R6: start strobe only after remap has been in effect for a cycle
  assert_go_after_remap_R6: assert property (@(posedge clk) disable iff (!rstN)
    goUser |-> $past(remapUser));

  // R6: start strobe lasts one cycle
  assert_go_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    goUser |=> !goUser);

  // R6: remap, once switched, stays switched
  assert_remap_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    remapUser |=> remapUser);

  // R7: programming mode never coexists with a user remap
  assert_isp_no_remap_R7: assert property (@(posedge clk) disable iff (!rstN)
    enterIsp |-> !remapUser);

  // R8: completion is sticky
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> seqDone);

endmodule

// File: rtl/boot_path_sequencer.sv
module boot_path_sequencer
  import boot_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VEC_WORDS   = 8,
  parameter int unsigned VEC_BASE    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtFlag,
  input  logic              bootPin,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              remapUser,
  output logic              goUser,
  output logic              enterIsp,
  output logic              seqDone
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  boot_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wdtFlag   (wdtFlag),
    .status    (status),
    .strobes   (strobes),
    .remapUser (remapUser),
    .goUser    (goUser),
    .enterIsp  (enterIsp),
    .seqDone   (seqDone)
  );

  boot_seq_datapath #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .VEC_WORDS   (VEC_WORDS),
    .VEC_BASE    (VEC_BASE),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .bootPin (bootPin),
    .memAck  (memAck),
    .memData (memData),
    .memReq  (memReq),
    .memAddr (memAddr),
    .status  (status)
  );

endmodule

// File: tb/boot_path_sequencer_tb_top.sv
module boot_path_sequencer_tb_top;

  typedef struct {
    bit    user;
    int    reads;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wdtFlag = 1'b0;
  logic        bootPin = 1'b0;
  logic        memAck;
  logic [31:0] memData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        remapUser, goUser, enterIsp, seqDone;

  int checks = 0;
  int fails = 0;
  int readCount;
  int waitCnt;
  int baseDelay = 0;
  bit spuriousAck = 1'b0;
  logic [31:0] vecTable [8];

  expItem_t expQ[$];
  int  verdictCount = 0;
  int  goCount;
  bit  prevRemap;
  bit  doneSeen;
  int  settle;

  always #2 clk = ~clk;

  boot_path_sequencer dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .wdtFlag   (wdtFlag),
    .bootPin   (bootPin),
    .memAck    (memAck),
    .memData   (memData),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .remapUser (remapUser),
    .goUser    (goUser),
    .enterIsp  (enterIsp),
    .seqDone   (seqDone)
  );

  task automatic checkIt(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // flash responder: acknowledge after a per-word delay, checking each address (R5)
  always @(negedge clk) begin
    if (!rstN) begin
      memAck    <= 1'b0;
      memData   <= '0;
      waitCnt   = 0;
      readCount = 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (spuriousAck) begin
      memAck  <= 1'b1;
      memData <= 32'h1;
    end else if (memReq) begin
      if (waitCnt >= baseDelay + (readCount % 2)) begin
        checkIt(memAddr == 32'(readCount * 4), "R5", "read address", memAddr,
                32'(readCount * 4));
        memData   <= vecTable[readCount & 7];
        memAck    <= 1'b1;
        readCount = readCount + 1;
        waitCnt   = 0;
      end else begin
        waitCnt = waitCnt + 1;
      end
    end
  end

  // monitor: pop expected outcome once the decision has settled
  always @(negedge clk) begin
    if (!rstN) begin
      goCount   = 0;
      prevRemap = 1'b0;
      doneSeen  = 1'b0;
      settle    = 0;
    end else begin
      if (goUser) begin
        goCount = goCount + 1;
        checkIt(prevRemap, "R6", "remap before start strobe", 32'(prevRemap), 32'd1);
      end
      prevRemap = remapUser;
      if (seqDone && !doneSeen) begin
        doneSeen = 1'b1;
        settle   = 3;
      end else if (settle > 0) begin
        settle = settle - 1;
        if (settle == 0) begin
          expItem_t e;
          e = expQ.pop_front();
          $display("verdict for %s", e.tag);
          checkIt(remapUser == e.user, "R6", "remapUser", 32'(remapUser), 32'(e.user));
          checkIt(enterIsp == !e.user, "R7", "enterIsp", 32'(enterIsp), 32'(!e.user));
          checkIt(goCount == (e.user ? 1 : 0), "R6", "start pulses", 32'(goCount),
                  32'(e.user ? 1 : 0));
          checkIt(readCount == e.reads, "R2 R3 R4", "table reads", 32'(readCount),
                  32'(e.reads));
          checkIt(seqDone == 1'b1, "R8", "seqDone", 32'(seqDone), 32'd1);
          verdictCount++;
        end
      end
    end
  end

  // driver: one full decision per call
  task automatic runCase(input bit wdt, input bit pin, input bit dropPin,
                         input int delay, input bit wantZero,
                         input logic [31:0] seed, input string tag);
    logic [31:0] partial;
    logic [31:0] total;
    expItem_t    e;
    int          target;
    logic        holdRemap, holdIsp;

    @(negedge clk);
    rstN      = 1'b0;
    wdtFlag   = wdt;
    bootPin   = pin;
    baseDelay = delay;
    partial   = '0;
    for (int i = 0; i < 7; i++) begin
      vecTable[i] = seed + 32'(i) * 32'h9E37_79B9;
      partial     = partial + vecTable[i];
    end
    vecTable[7] = wantZero ? (32'd0 - partial) : (32'd0 - partial + 32'h100);
    total = '0;
    for (int i = 0; i < 8; i++) total = total + vecTable[i];

    e.user  = (wdt || pin) && (total == 32'd0);
    e.reads = (wdt || pin) ? 8 : 0;
    e.tag   = tag;
    expQ.push_back(e);

    repeat (3) @(negedge clk);
    // R1 / R9: reset state
    checkIt({memReq, remapUser, goUser, enterIsp, seqDone} == 5'b0, "R1",
            "outputs in reset", 32'({memReq, remapUser, goUser, enterIsp, seqDone}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkIt({memReq, remapUser, goUser, enterIsp, seqDone} == 5'b0, "R9",
            "outputs after release", 32'({memReq, remapUser, goUser, enterIsp, seqDone}),
            32'd0);

    if (dropPin) begin
      while (!memReq && !seqDone) @(negedge clk);
      bootPin = 1'b0;  // R10: late pin change must not count
    end

    target = verdictCount + 1;
    while (verdictCount < target) @(negedge clk);

    // R8: stimulate everything after completion
    holdRemap   = remapUser;
    holdIsp     = enterIsp;
    wdtFlag     = ~wdtFlag;
    bootPin     = ~bootPin;
    spuriousAck = 1'b1;
    repeat (2) @(negedge clk);
    spuriousAck = 1'b0;
    repeat (3) @(negedge clk);
    checkIt(remapUser == holdRemap, "R8", "remap after done", 32'(remapUser), 32'(holdRemap));
    checkIt(enterIsp == holdIsp, "R8", "enterIsp after done", 32'(enterIsp), 32'(holdIsp));
    checkIt(goUser == 1'b0, "R8", "no start after done", 32'(goUser), 32'd0);
    checkIt(memReq == 1'b0, "R8", "no read after done", 32'(memReq), 32'd0);
    checkIt(seqDone == 1'b1, "R8", "done held", 32'(seqDone), 32'd1);
    checkIt(readCount == e.reads, "R8", "read count frozen", 32'(readCount), 32'(e.reads));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    printSummary();
    $finish;
  end

  initial begin
    memAck  = 1'b0;
    memData = '0;
    runCase(1'b0, 1'b1, 1'b0, 0, 1'b1, 32'h1234_5678, "R4 pin high, valid table, zero wait");
    runCase(1'b0, 1'b0, 1'b0, 0, 1'b1, 32'h0BAD_F00D, "R3 pin low, programming mode");
    runCase(1'b1, 1'b0, 1'b0, 3, 1'b1, 32'hCAFE_0001, "R2 watchdog reset ignores low pin");
    runCase(1'b1, 1'b1, 1'b0, 1, 1'b0, 32'h0000_0042, "R7 watchdog reset, bad checksum");
    runCase(1'b0, 1'b1, 1'b0, 5, 1'b0, 32'hFFFF_FF00, "R7 pin high, bad checksum, slow acks");
    runCase(1'b0, 1'b1, 1'b1, 2, 1'b1, 32'hFFFF_FFF0, "R10 wrapping sum, pin drops mid-read");
    printSummary();
    $finish;
  end

endmodule